// File: doc/BRIEF.md
# Three-Digit Crosswise 8x8 Unsigned Multiplier

This block multiplies two unsigned 8-bit operands and returns the full 16-bit product in the same cycle. It has no clock or storage. Each operand is cut into three digits of unequal width: a 3-bit low digit, a 3-bit middle digit and a 2-bit high digit. Every pair of digits that meets in a column is multiplied by a small select-driven multiplier. In that multiplier, one digit chooses among precomputed shift-and-add lines of the other digit.

The nine digit products are summed in five columns, with the column of lowest weight first. Each of the first four columns keeps its low three bits as product bits and passes the bits above them as a carry into the next column. The fifth column supplies the top four product bits.

The unit uses one 2x2, four 3x2 and four 3x3 digit multipliers. It is meant for use inside datapaths such as filter or matrix engines, where a small unsigned multiply is needed without a pipeline stage.

Top module: `xw_mul8`

## Requirements
- R1: Operand bits are grouped as low digit [2:0], middle digit [5:3] and high digit [7:6]. An operand whose only nonzero digit is the middle one, multiplied by 1, returns that operand unchanged.
- R2: Product bits [2:0] equal (x_lo*y_lo) mod 8, where x is `mcand_i` and y is `mplier_i`.
- R3: Product bits [5:3] equal (x_mid*y_lo + x_lo*y_mid + carry1) mod 8. Here carry1 is x_lo*y_lo divided by 8.
- R4: Product bits [8:6] equal (x_lo*y_hi + x_hi*y_lo + x_mid*y_mid + carry2) mod 8. Here carry2 is the column-2 sum divided by 8.
- R5: Product bits [11:9] equal (x_hi*y_mid + x_mid*y_hi + carry3) mod 8. Here carry3 is the column-3 sum divided by 8.
- R6: Product bits [15:12] equal x_hi*y_hi + carry4, where carry4 is the column-4 sum divided by 8. This sum never exceeds 15.
- R7: For every pair of operands, `prod_o` equals the exact product x*y.
- R8: If either operand is zero, `prod_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand_i | input | 8 | Unsigned multiplicand x |
| mplier_i | input | 8 | Unsigned multiplier y |
| prod_o | output | 16 | Unsigned product x*y |

## Verification
The checker assumes only that both operands hold known values (no X or Z bits). Under that assumption, every column sum stays bounded and the carries stay narrow enough for the fixed field widths. The checks are immediate, so they also assume they are read once the combinational network has settled. The stimulus drives only fully defined 8-bit values. It changes them once per clock, right after a rising edge, and reads the outputs at the following falling edge. The operand space is covered exhaustively, so the carry bounds are reached at their largest values.

// File: rtl/xw_mul8_pkg.sv
package xw_mul8_pkg;
  localparam int OP_W    = 8;
  localparam int PROD_W  = 2 * OP_W;
  localparam int LO_W    = 3;
  localparam int MID_W   = 3;
  localparam int HI_W    = OP_W - LO_W - MID_W;
  localparam int DIG_W   = 3;
  localparam int NCOL    = 5;
  localparam int COL_W   = 7;
  localparam int TERM_W  = LO_W + MID_W;
  localparam int CARRY_W = COL_W - DIG_W;
  localparam int TOP_W   = PROD_W - (NCOL - 1) * DIG_W;

  // Operand viewed as three digits; the packed layout places the low digit at bit 0
  typedef struct packed {
    logic [HI_W-1:0]  hi;
    logic [MID_W-1:0] mid;
    logic [LO_W-1:0]  lo;
  } digits_t;

  // Digit kept in the product from a column sum
  function automatic logic [DIG_W-1:0] col_digit(input logic [COL_W-1:0] s);
    return s[DIG_W-1:0];
  endfunction

  // Carry passed to the next column, widened to a column sum
  function automatic logic [COL_W-1:0] col_carry(input logic [COL_W-1:0] s);
    logic [CARRY_W-1:0] c;
    c = s[COL_W-1:DIG_W];
    return COL_W'(c);
  endfunction
endpackage

// File: rtl/xw_sel_mul.sv
module xw_sel_mul #(
  parameter int DW = 3,
  parameter int SW = 3
) (
  input  logic [DW-1:0]    data_i,
  input  logic [SW-1:0]    sel_i,
  output logic [DW+SW-1:0] prod_o
);
  localparam int PW   = DW + SW;
  localparam int NSEL = 1 << SW;

  logic [NSEL-1:0][PW-1:0] lines;

  // Line value for one select code: the data shifted by each set code bit, summed
  function automatic logic [PW-1:0] line_val(input logic [DW-1:0] d, input int code);
    logic [PW-1:0] acc;
    acc = '0;
    for (int i = 0; i < SW; i++) begin
      if (((code >> i) & 1) == 1) acc = acc + (PW'(d) << i);
    end
    return acc;
  endfunction

  for (genvar k = 0; k < NSEL; k++) begin : g_line
    assign lines[k] = line_val(data_i, k);
  end

  assign prod_o = lines[sel_i];
endmodule

// File: rtl/xw_col_sum.sv
module xw_col_sum #(
  parameter int NT   = 2,
  parameter int TW   = 6,
  parameter int SUMW = 7
) (
  input  logic [NT-1:0][TW-1:0] terms_i,
  input  logic [SUMW-1:0]       cin_i,
  output logic [SUMW-1:0]       sum_o
);
  always_comb begin
    sum_o = cin_i;
    for (int t = 0; t < NT; t++) sum_o = sum_o + SUMW'(terms_i[t]);
  end
endmodule

// File: rtl/xw_mul8.sv
module xw_mul8
  import xw_mul8_pkg::*;
(
  input  logic [OP_W-1:0]   mcand_i,
  input  logic [OP_W-1:0]   mplier_i,
  output logic [PROD_W-1:0] prod_o
);
  localparam int NSQ = 4;
  localparam int NRC = 4;
  localparam int SQ_W = LO_W + MID_W;
  localparam int RC_W = LO_W + HI_W;
  localparam int HH_W = 2 * HI_W;

  digits_t dx, dy;
  assign dx = digits_t'(mcand_i);
  assign dy = digits_t'(mplier_i);

  // 3x3 cells: 0 lo*lo, 1 mid(x)*lo(y), 2 lo(x)*mid(y), 3 mid*mid
  logic [NSQ-1:0][2:0]      sq_d, sq_s;
  logic [NSQ-1:0][SQ_W-1:0] sq_p;
  assign sq_d = {dx.mid, dx.lo, dx.mid, dx.lo};
  assign sq_s = {dy.mid, dy.mid, dy.lo, dy.lo};

  // 3x2 cells: 0 lo(y)*hi(x), 1 lo(x)*hi(y), 2 mid(y)*hi(x), 3 mid(x)*hi(y)
  logic [NRC-1:0][2:0]      rc_d;
  logic [NRC-1:0][HI_W-1:0] rc_s;
  logic [NRC-1:0][RC_W-1:0] rc_p;
  assign rc_d = {dx.mid, dy.mid, dx.lo, dy.lo};
  assign rc_s = {dy.hi, dx.hi, dy.hi, dx.hi};

  logic [HH_W-1:0] hh_p;

  for (genvar i = 0; i < NSQ; i++) begin : g_sq
    xw_sel_mul #(.DW(3), .SW(3)) u_cell (
      .data_i(sq_d[i]), .sel_i(sq_s[i]), .prod_o(sq_p[i])
    );
  end

  for (genvar i = 0; i < NRC; i++) begin : g_rc
    xw_sel_mul #(.DW(3), .SW(HI_W)) u_cell (
      .data_i(rc_d[i]), .sel_i(rc_s[i]), .prod_o(rc_p[i])
    );
  end

  xw_sel_mul #(.DW(HI_W), .SW(HI_W)) u_hh (
    .data_i(dx.hi), .sel_i(dy.hi), .prod_o(hh_p)
  );

  // Named column sums, brought out for the checker
  logic [COL_W-1:0] col1_sum, col2_sum, col3_sum, col4_sum, col5_sum;

  xw_col_sum #(.NT(1), .TW(TERM_W), .SUMW(COL_W)) u_col1 (
    .terms_i(sq_p[0]), .cin_i('0), .sum_o(col1_sum)
  );
  xw_col_sum #(.NT(2), .TW(TERM_W), .SUMW(COL_W)) u_col2 (
    .terms_i({sq_p[1], sq_p[2]}), .cin_i(col_carry(col1_sum)), .sum_o(col2_sum)
  );
  xw_col_sum #(.NT(3), .TW(TERM_W), .SUMW(COL_W)) u_col3 (
    .terms_i({TERM_W'(rc_p[0]), TERM_W'(rc_p[1]), sq_p[3]}),
    .cin_i(col_carry(col2_sum)), .sum_o(col3_sum)
  );
  xw_col_sum #(.NT(2), .TW(TERM_W), .SUMW(COL_W)) u_col4 (
    .terms_i({TERM_W'(rc_p[2]), TERM_W'(rc_p[3])}),
    .cin_i(col_carry(col3_sum)), .sum_o(col4_sum)
  );
  xw_col_sum #(.NT(1), .TW(TERM_W), .SUMW(COL_W)) u_col5 (
    .terms_i(TERM_W'(hh_p)), .cin_i(col_carry(col4_sum)), .sum_o(col5_sum)
  );

  assign prod_o = {col5_sum[TOP_W-1:0], col_digit(col4_sum), col_digit(col3_sum),
                   col_digit(col2_sum), col_digit(col1_sum)};
endmodule

// File: rtl/xw_mul8_chk.sv
module xw_mul8_chk
  import xw_mul8_pkg::*;
(
  input logic [OP_W-1:0]   mcand_i,
  input logic [OP_W-1:0]   mplier_i,
  input logic [PROD_W-1:0] prod_o,
  input logic [COL_W-1:0]  col1_sum,
  input logic [COL_W-1:0]  col2_sum,
  input logic [COL_W-1:0]  col5_sum
);
  always_comb begin
    if (!$isunknown({mcand_i, mplier_i})) begin
      // R7
      prod_exact_chk: assert (prod_o == PROD_W'(mcand_i) * PROD_W'(mplier_i));
      // R2
      col1_digit_chk: assert (prod_o[2:0] == col1_sum[2:0]);
      // R3
      col2_digit_chk: assert (prod_o[5:3] == col2_sum[2:0]);
      // R6
      top_fit_chk: assert (col5_sum < COL_W'(1 << TOP_W));
      // R8
      zero_operand_chk: assert (!(mcand_i == '0 || mplier_i == '0) || prod_o == '0);
    end
  end
endmodule

bind xw_mul8 xw_mul8_chk chk_i (
  .mcand_i(mcand_i), .mplier_i(mplier_i), .prod_o(prod_o),
  .col1_sum(col1_sum), .col2_sum(col2_sum), .col5_sum(col5_sum)
);

// File: tb/xw_mul8_tb_top.sv
module xw_mul8_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  x, y;
  logic [15:0] p;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xw_mul8 dut_i (.mcand_i(x), .mplier_i(y), .prod_o(p));

  // {x, y, expected product}
  localparam logic [31:0] VEC [14] = '{
    {8'd0,   8'd0,   16'd0},     {8'd1,   8'd1,   16'd1},
    {8'd255, 8'd255, 16'd65025}, {8'd255, 8'd1,   16'd255},
    {8'd1,   8'd255, 16'd255},   {8'd128, 8'd128, 16'd16384},
    {8'd2,   8'd64,  16'd128},   {8'd255, 8'd0,   16'd0},
    {8'd0,   8'd200, 16'd0},     {8'd7,   8'd7,   16'd49},
    {8'd56,  8'd56,  16'd3136},  {8'd192, 8'd192, 16'd36864},
    {8'd170, 8'd85,  16'd14450}, {8'd100, 8'd200, 16'd20000}
  };

  task automatic check(input string tag, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s x=%0d y=%0d actual=%0d expected=%0d", tag, x, y, act, exp_v);
    end
  endtask

  // Column digits restated from the requirements, lowest column first
  task automatic check_cols();
    int xl, xm, xh, yl, ym, yh, s1, s2, s3, s4, s5;
    xl = int'(x) % 8; xm = (int'(x) / 8) % 8; xh = int'(x) / 64;
    yl = int'(y) % 8; ym = (int'(y) / 8) % 8; yh = int'(y) / 64;
    s1 = xl * yl;
    s2 = xm * yl + xl * ym + s1 / 8;
    s3 = xl * yh + xh * yl + xm * ym + s2 / 8;
    s4 = xh * ym + xm * yh + s3 / 8;
    s5 = xh * yh + s4 / 8;
    check("R2 col1", int'(p[2:0]),   s1 % 8);
    check("R3 col2", int'(p[5:3]),   s2 % 8);
    check("R4 col3", int'(p[8:6]),   s3 % 8);
    check("R5 col4", int'(p[11:9]),  s4 % 8);
    check("R6 col5", int'(p[15:12]), s5);
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] b);
    @(posedge clk);
    x = a; y = b;
    @(negedge clk);
  endtask

  initial begin
    x = '0; y = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset-time zero", int'(p), 0);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      apply(VEC[i][31:24], VEC[i][23:16]);
      check("R7 table", int'(p), int'(VEC[i][15:0]));
      check_cols();
    end

    // R1: middle digit alone times one
    for (int m = 0; m < 8; m++) begin
      apply(8'(m * 8), 8'd1);
      check("R1 mid digit", int'(p), m * 8);
    end

    // R8: zero on either side
    apply(8'd0, 8'd173); check("R8 x zero", int'(p), 0);
    apply(8'd91, 8'd0);  check("R8 y zero", int'(p), 0);

    // Powers of two
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        apply(8'(1 << i), 8'(1 << j));
        check("R7 pow2", int'(p), 1 << (i + j));
        check_cols();
      end
    end

    // Every operand pair
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        apply(8'(a), 8'(b));
        check("R7 exhaustive", int'(p), a * b);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule